// File: doc/BRIEF.md
# PCI Bus Master Tenure Timer

This block caps how long a PCI bus master may keep bursting after it has won the bus. Software programs a five-bit tenure field in an 8-bit configuration register. The field counts in units of eight PCI clocks.

When the master starts a granted cycle, the block loads a down-counter with the programmed tenure. The counter begins to decrement on the clock where FRAME# is asserted. When the counter has run out, the block checks the internal grant:

- If the grant has been withdrawn, it sends the master state machine a one-clock request to end the burst by deasserting FRAME#.
- If the grant is still held, the master keeps the bus and no request is raised.

The master state machine owns the cycle boundaries. It signals the start of a granted cycle, the FRAME# assertion and the end of the transaction. The block only decides when the burst must stop.

Top module: `pci_tenure_timer`

## Requirements
- R1: The configuration register holds a 5-bit tenure field in bits 7:3. A write stores `cfg_wdata[7:3]`. `cfg_rdata` returns the field in bits 7:3 and zero in bits 2:0. Write data in bits 2:0 is ignored.
- R2: After a synchronous active-low reset, `cfg_rdata` reads 00h and `term_req` is low.
- R3: `cycle_start` loads the counter with field×8. Counting begins on the clock edge that samples `frame_start`. The timer expires after max(field×8, 1) edges, with the `frame_start` edge counted as the first. The counter then holds at zero.
- R4: When the timer has expired and `gnt` is sampled low, `term_req` is high for the clock after that edge.
- R5: While `gnt` stays high, `term_req` never rises, even after expiry.
- R6: If `gnt` falls after expiry, `term_req` rises after the first edge that samples `gnt` low.
- R7: A field of zero expires on the `frame_start` edge itself. A master without grant is then told to terminate on the next edge.
- R8: `term_req` lasts exactly one clock and is raised at most once per transaction.
- R9: `xact_end` clears the expired state and any pending request. The next `cycle_start` reloads the counter from the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the tenure register |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| gnt | input | 1 | Internal bus grant, high while granted |
| cycle_start | input | 1 | Pulse: master starts a granted cycle |
| frame_start | input | 1 | Pulse: FRAME# asserted this clock |
| xact_end | input | 1 | Pulse: transaction finished |
| term_req | output | 1 | One-clock request to deassert FRAME# |

## Verification
Each transaction scenario changes one thing: the tenure field (zero, small, maximum) or the clock on which the grant drops (before expiry, well after expiry, never). This separates an off-by-one in the load or count start from a wrong grant qualification. A scenario that keeps the grant shows whether the block cuts off a master it should not. Back-to-back transactions with new field values show whether the reload and the end-of-transaction clearing take effect. Writes with the reserved bits set show whether those bits leak into the count or the readback.

// File: rtl/tenure_pkg.sv
// Package: shared widths for the bus-master tenure timer.
// Assumes the register is split into a tenure field above a reserved low part.
package tenure_pkg;
    localparam int REG_W   = 8;                 // configuration register width
    localparam int FIELD_W = 5;                 // tenure field width
    localparam int STEP_LG = REG_W - FIELD_W;   // log2 of clocks per step
    localparam int CNT_W   = FIELD_W + STEP_LG; // counter width

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [CNT_W-1:0]   count_t;
endpackage

// File: rtl/tenure_cfg_reg.sv
// Module: tenure configuration register.
// Stores the tenure field from the upper bits of a write.
// The low reserved bits read back as zero.
// Assumes writes are single-cycle strobes in the PCI clock domain.
module tenure_cfg_reg
    import tenure_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output field_t           field
);
    // Purpose: capture the tenure field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field <= '0;
        else if (wr_en)
            field <= wdata[REG_W-1:STEP_LG];
    end

    // Purpose: form read data with the reserved bits as zero.
    always_comb begin
        rdata = {field, {STEP_LG{1'b0}}};
    end

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> field == $past(wdata[REG_W-1:STEP_LG]));
endmodule

// File: rtl/tenure_counter.sv
// Module: tenure down-counter.
// Loads field*8 at the start of a granted cycle.
// Decrements from the FRAME# edge onward and holds at zero.
// Assumes cycle_start has priority over xact_end, and xact_end over frame_start.
module tenure_counter
    import tenure_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  field_t field,
    input  logic   cycle_start,
    input  logic   frame_start,
    input  logic   xact_end,
    output logic   expired
);
    count_t cnt;
    logic   active;
    logic   counting;

    // Purpose: a clock counts if FRAME# is asserted now or counting is already under way.
    always_comb begin
        counting = frame_start | active;
    end

    // Purpose: load, start, decrement and stop the tenure count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (cycle_start) begin
            cnt    <= {field, {STEP_LG{1'b0}}};
            active <= 1'b0;
        end else if (xact_end) begin
            active <= 1'b0;
        end else begin
            if (frame_start)
                active <= 1'b1;
            if (counting && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Purpose: flag expiry once counting has begun and the count is spent.
    always_comb begin
        expired = active && (cnt == '0);
    end

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> cnt == {$past(field), {STEP_LG{1'b0}}});
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !cycle_start) |=> cnt == '0);
    p_no_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !frame_start && !cycle_start) |=> $stable(cnt));
endmodule

// File: rtl/tenure_term.sv
// Module: burst-terminate request generator.
// Raises a registered one-clock request when the timer has expired
// and the grant is gone, at most once per transaction.
module tenure_term (
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic gnt,
    input  logic cycle_start,
    input  logic xact_end,
    output logic term_req
);
    logic fired;

    // Purpose: issue the single terminate pulse and remember that it was sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_req <= 1'b0;
            fired    <= 1'b0;
        end else if (cycle_start || xact_end) begin
            term_req <= 1'b0;
            fired    <= 1'b0;
        end else if (expired && !gnt && !fired) begin
            term_req <= 1'b1;
            fired    <= 1'b1;
        end else begin
            term_req <= 1'b0;
        end
    end

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |=> !term_req);
    p_needs_no_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |-> !$past(gnt));
    p_after_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |-> $past(expired));
endmodule

// File: rtl/pci_tenure_timer.sv
// Module: PCI bus-master tenure timer (top).
// Joins the configuration register, the down-counter and the terminate generator.
// Assumes the control pulses come from the master state machine in the same clock domain.
module pci_tenure_timer
    import tenure_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             gnt,
    input  logic             cycle_start,
    input  logic             frame_start,
    input  logic             xact_end,
    output logic             term_req
);
    field_t field;
    logic   expired;

    tenure_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .field (field)
    );

    tenure_counter u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .field       (field),
        .cycle_start (cycle_start),
        .frame_start (frame_start),
        .xact_end    (xact_end),
        .expired     (expired)
    );

    tenure_term u_term (
        .clk         (clk),
        .rst_n       (rst_n),
        .expired     (expired),
        .gnt         (gnt),
        .cycle_start (cycle_start),
        .xact_end    (xact_end),
        .term_req    (term_req)
    );

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xact_end |=> !term_req);
endmodule

// File: tb/sim_pci_tenure_timer.sv
module sim_pci_tenure_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       gnt = 1'b1;
    logic       cycle_start = 1'b0;
    logic       frame_start = 1'b0;
    logic       xact_end = 1'b0;
    logic       term_req;

    int checks = 0;
    int errors = 0;
    bit     exp_q[$];
    string  tag_q[$];
    bit     done = 1'b0;

    always #5 clk = ~clk;

    pci_tenure_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .gnt(gnt), .cycle_start(cycle_start),
        .frame_start(frame_start), .xact_end(xact_end), .term_req(term_req)
    );

    // Monitor: pop one expected term_req value per cycle, after the edge has settled.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (term_req !== e) begin
                    errors++;
                    $display("FAIL %s term_req actual=%0b expected=%0b at %0t", t, term_req, e, $time);
                end
            end
        end
    end

    task automatic check_rd(input logic [7:0] expv, input string t);
        checks++;
        if (cfg_rdata !== expv) begin
            errors++;
            $display("FAIL %s cfg_rdata actual=%02h expected=%02h", t, cfg_rdata, expv);
        end
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Driver: one transaction. Grant is low from cycle d on. Expected pulse at
    // cycle T = max(max(8N,1)+1, d) when the grant drops before cycle len.
    task automatic run_xact(input int n, input int d, input int len, input string t);
        int tgt;
        int e1;
        e1  = (n * 8 > 1) ? n * 8 : 1;
        tgt = (e1 + 1 > d) ? e1 + 1 : d;
        if (tgt >= len) tgt = -1;
        for (int i = 0; i <= len + 2; i++) begin
            @(negedge clk);
            cycle_start = (i == 0);
            frame_start = (i == 1);
            xact_end    = (i == len);
            gnt         = (i < d) ? 1'b1 : 1'b0;
            if (i > len) gnt = 1'b1;
            exp_q.push_back(i == tgt);
            tag_q.push_back(t);
        end
        @(negedge clk);
        xact_end = 1'b0;
        gnt = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state.
        check_rd(8'h00, "R2");
        checks++;
        if (term_req !== 1'b0) begin
            errors++;
            $display("FAIL R2 term_req actual=%0b expected=0", term_req);
        end
        rst_n = 1'b1;

        // R1: reserved bits ignored and read as zero.
        write_cfg(8'hFF); check_rd(8'hF8, "R1");
        write_cfg(8'h07); check_rd(8'h00, "R1");
        write_cfg(8'h5A); check_rd(8'h58, "R1");

        // R3 R4: field 2, grant lost early, pulse when the count runs out.
        write_cfg(8'h10);
        run_xact(2, 5, 25, "R3_R4");
        // R5: grant kept, no request even after expiry.
        run_xact(2, 1000, 30, "R5");
        // R6: field 1, grant dropped well after expiry.
        write_cfg(8'h08);
        run_xact(1, 20, 25, "R6");
        // R7: zero field, no grant from the start.
        write_cfg(8'h03);
        run_xact(0, 0, 8, "R7");
        // R8 R3: maximum field with reserved bits set, long hold without grant.
        write_cfg(8'hFF);
        run_xact(31, 0, 256, "R8_R3");
        // R9: fresh transaction after end, reloaded with a new field.
        write_cfg(8'h18);
        run_xact(3, 2, 40, "R9");
        run_xact(3, 30, 40, "R9");

        repeat (4) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule